// File: doc/BRIEF.md
# Depth-from-Focus Row Ranging Engine

This block estimates object distance from one frame of a tilted image sensor. The sensor plane sits at an angle to the lens axis, so exactly one sensor row is in sharp focus for a given object distance. Pixels arrive one at a time in raster order, each marked as the start of a frame or the end of a row where that applies. For every row the engine builds a sharpness score: the sum, over the interior pixels, of the magnitude of the discrete second spatial derivative. When the last row closes, the engine reports the sharpest row and an 8-bit distance code in half-metre units.

The frame geometry is set by parameters. The default is 18 rows of 16 pixels, with 8-bit unsigned pixels. The sharpest row maps linearly to distance: row 1 is the nearest range, 1.5 m, and each later row adds 0.5 m. A done pulse marks each new result. The result then holds until the next frame completes. Frames whose rows all score zero are flagged as carrying no focus information.

Top module: `rng_focus_ranger`

## Requirements
- R1: Each interior pixel at column i contributes |2*V[i] - V[i-1] - V[i+1]|, using its two neighbours in the same row. Negative and positive second derivatives both add their magnitude to the score.
- R2: A row's score is the sum of the terms for columns 1 to COLS-2 (0-based). Edge pixels add no term of their own. No term ever uses a pixel from another row. The pixel flagged with in_eor closes the row.
- R3: The reported row is the one with the largest score in the frame. When scores tie, the lower-numbered row wins.
- R4: res_row is 1-based. res_code is an unsigned count of half-metres equal to res_row + 2. Row 1 gives 3 (1.5 m), row 10 gives 12 (6 m), row 13 gives 15 (7.5 m) and row 18 gives 20 (10 m).
- R5: When every row of a frame scores zero, the engine reports res_row = 1 and res_code = 3 with res_nofocus = 1. Otherwise res_nofocus = 0.
- R6: res_done is high for exactly one cycle. That cycle follows the clock edge that accepts the end-of-row pixel of the last row. res_row, res_code and res_nofocus hold their values until the next such pulse.
- R7: A pixel is taken only when in_valid and in_ready are both high. Cycles with in_valid low have no effect, whatever the other inputs carry. in_ready is high in every cycle from the third clock after reset release.
- R8: While reset is asserted, res_done, res_row, res_code, res_nofocus and in_ready are all 0.
- R9: A pixel flagged with in_sof starts a new frame at row 0, column 0. Any partly received frame is discarded and cannot influence the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on in_pix |
| in_ready | output | 1 | Engine accepts a pixel this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eor | input | 1 | Pixel is the last of its row |
| in_pix | input | 8 | Unsigned pixel intensity |
| res_done | output | 1 | One-cycle pulse: new result available |
| res_row | output | 5 | Sharpest row, 1-based |
| res_code | output | 8 | Distance in half-metre units |
| res_nofocus | output | 1 | Every row of the frame scored zero |

## Verification
The bench builds the engine with its default geometry: 18 rows, 16 columns and 8-bit pixels. This puts both ends of the distance table within reach, codes 3 and 20, along with the full-scale alternating 0/255 row that drives the row accumulator close to its bound. At this size the bench can also craft rows whose scores differ by only a few units, or tie exactly. That lets it separate the correct tie rule, magnitude handling and row-boundary windowing from plausible faults. Idle gaps carrying junk flags, and a frame abandoned partway through, exercise the acceptance and restart rules.

// File: rtl/rng_pkg.sv
package rng_pkg;

  // width of one |second derivative| term
  function automatic int unsigned term_width(input int unsigned pix_w);
    return pix_w + 2;
  endfunction

  // width of a row score holding COLS-2 terms
  function automatic int unsigned score_width(input int unsigned pix_w,
                                              input int unsigned cols);
    return term_width(pix_w) + $clog2(cols - 2);
  endfunction

  // largest score a legal row can produce
  function automatic int unsigned max_score(input int unsigned pix_w,
                                            input int unsigned cols);
    return (cols - 2) * 2 * ((1 << pix_w) - 1);
  endfunction

endpackage

// File: rtl/rng_lap_term.sv
module rng_lap_term #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned TERM_W = PIX_W + 2
) (
  input  logic [PIX_W-1:0]  left_px,
  input  logic [PIX_W-1:0]  mid_px,
  input  logic [PIX_W-1:0]  right_px,
  output logic [TERM_W-1:0] mag
);
  localparam int unsigned DW = PIX_W + 3;

  logic signed [DW-1:0] diff;

  // 2*mid - left - right, then magnitude (both signs count)
  always_comb begin
    diff = $signed({2'b00, mid_px, 1'b0})
         - $signed({3'b000, left_px})
         - $signed({3'b000, right_px});
    if (diff[DW-1]) mag = TERM_W'(-diff);
    else            mag = TERM_W'(diff);
  end
endmodule

// File: rtl/rng_row_accum.sv
module rng_row_accum #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned COLS    = 16,
  parameter int unsigned TERM_W  = rng_pkg::term_width(PIX_W),
  parameter int unsigned SCORE_W = rng_pkg::score_width(PIX_W, COLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               sof,
  input  logic               eor,
  input  logic [PIX_W-1:0]   pix,
  output logic               row_close,
  output logic [SCORE_W-1:0] row_score
);
  localparam int unsigned COL_W     = $clog2(COLS);
  localparam int unsigned MAX_SCORE = rng_pkg::max_score(PIX_W, COLS);

  logic [PIX_W-1:0]   prev1_q, prev1_d, prev2_q, prev2_d;
  logic [COL_W-1:0]   col_q, col_d, eff_col;
  logic [SCORE_W-1:0] acc_q, acc_d, acc_base;
  logic [TERM_W-1:0]  term_mag;
  logic               term_ok;

  rng_lap_term #(.PIX_W(PIX_W), .TERM_W(TERM_W)) u_term (
    .left_px (prev2_q),
    .mid_px  (prev1_q),
    .right_px(pix),
    .mag     (term_mag)
  );

  always_comb begin
    eff_col   = sof ? '0 : col_q;
    term_ok   = (eff_col >= COL_W'(2));
    acc_base  = (eff_col == '0) ? '0 : acc_q;
    row_score = acc_base + (term_ok ? SCORE_W'(term_mag) : '0);
    row_close = take & eor;
  end

  always_comb begin
    prev1_d = prev1_q;
    prev2_d = prev2_q;
    col_d   = col_q;
    acc_d   = acc_q;
    if (take) begin
      prev2_d = prev1_q;
      prev1_d = pix;
      if (eor) begin
        col_d = '0;
        acc_d = '0;
      end else begin
        col_d = (eff_col == COL_W'(COLS - 1)) ? eff_col : eff_col + COL_W'(1);
        acc_d = row_score;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev1_q <= '0;
      prev2_q <= '0;
      col_q   <= '0;
      acc_q   <= '0;
    end else begin
      prev1_q <= prev1_d;
      prev2_q <= prev2_d;
      col_q   <= col_d;
      acc_q   <= acc_d;
    end
  end

  // R2: a closed row never exceeds the bound for COLS-2 terms
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    row_close |-> (32'(row_score) <= MAX_SCORE));

  // R2: the row restarts from zero after an end-of-row pixel
  a_r2_row_restart: assert property (@(posedge clk) disable iff (!rst_n)
    row_close |=> (acc_q == '0) && (col_q == '0));
endmodule

// File: rtl/rng_peak_pick.sv
module rng_peak_pick #(
  parameter int unsigned ROWS    = 18,
  parameter int unsigned SCORE_W = 14,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               sof,
  input  logic               row_close,
  input  logic [SCORE_W-1:0] row_score,
  output logic               frame_done,
  output logic [IDX_W-1:0]   win_idx,
  output logic [SCORE_W-1:0] win_score
);
  logic [IDX_W-1:0]   row_q, row_d, eff_row, idx_q, idx_d;
  logic [SCORE_W-1:0] best_q, best_d;
  logic               first, better, last;

  always_comb begin
    eff_row    = sof ? '0 : row_q;
    first      = (eff_row == '0);
    // strict compare: an equal later row never displaces an earlier one
    better     = first || (row_score > best_q);
    win_idx    = better ? eff_row : idx_q;
    win_score  = better ? row_score : best_q;
    last       = (eff_row == IDX_W'(ROWS - 1));
    frame_done = row_close && last;
  end

  always_comb begin
    row_d  = row_q;
    idx_d  = idx_q;
    best_d = best_q;
    if (take) begin
      if (row_close) row_d = last ? '0 : eff_row + IDX_W'(1);
      else           row_d = eff_row;
    end
    if (row_close) begin
      idx_d  = win_idx;
      best_d = win_score;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      idx_q  <= '0;
      best_q <= '0;
    end else begin
      row_q  <= row_d;
      idx_q  <= idx_d;
      best_q <= best_d;
    end
  end

  // R3: within a frame the running best never decreases
  a_r3_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (row_close && !sof && (row_q != '0)) |=> (best_q >= $past(best_q)));

  // R3: the winning index is always a row that has already been seen
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q < IDX_W'(ROWS)) && (row_q < IDX_W'(ROWS)));
endmodule

// File: rtl/rng_focus_ranger.sv
module rng_focus_ranger #(
  parameter int unsigned ROWS      = 18,
  parameter int unsigned COLS      = 16,
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned BASE_CODE = 3,
  parameter int unsigned CODE_STEP = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sof,
  input  logic                      in_eor,
  input  logic [PIX_W-1:0]          in_pix,
  output logic                      res_done,
  output logic [$clog2(ROWS+1)-1:0] res_row,
  output logic [CODE_W-1:0]         res_code,
  output logic                      res_nofocus
);
  localparam int unsigned TERM_W  = rng_pkg::term_width(PIX_W);
  localparam int unsigned SCORE_W = rng_pkg::score_width(PIX_W, COLS);
  localparam int unsigned IDX_W   = $clog2(ROWS + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic               rdy_q, take;
  logic               row_close, frame_done;
  logic [SCORE_W-1:0] row_score, win_score;
  logic [IDX_W-1:0]   win_idx;

  assign in_ready = rdy_q;
  assign take     = in_valid & rdy_q;

  rng_row_accum #(.PIX_W(PIX_W), .COLS(COLS), .TERM_W(TERM_W),
                  .SCORE_W(SCORE_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .take     (take),
    .sof      (in_sof),
    .eor      (in_eor),
    .pix      (in_pix),
    .row_close(row_close),
    .row_score(row_score)
  );

  rng_peak_pick #(.ROWS(ROWS), .SCORE_W(SCORE_W), .IDX_W(IDX_W)) u_peak (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .take      (take),
    .sof       (in_sof),
    .row_close (row_close),
    .row_score (row_score),
    .frame_done(frame_done),
    .win_idx   (win_idx),
    .win_score (win_score)
  );

  // row-to-distance table, one constant entry per row
  logic [CODE_W-1:0] code_tab [ROWS];
  for (genvar g = 0; g < ROWS; g++) begin : g_code
    assign code_tab[g] = CODE_W'(BASE_CODE + g * CODE_STEP);
  end

  logic [CODE_W-1:0] code_sel;
  always_comb begin
    code_sel = '0;
    for (int i = 0; i < ROWS; i++)
      if (win_idx == IDX_W'(i)) code_sel = code_tab[i];
  end

  logic              done_q, done_d, nof_q, nof_d, rdy_d;
  logic [IDX_W-1:0]  row_q, row_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    rdy_d  = 1'b1;
    done_d = frame_done;
    row_d  = row_q;
    code_d = code_q;
    nof_d  = nof_q;
    if (frame_done) begin
      row_d  = win_idx + IDX_W'(1);
      code_d = code_sel;
      nof_d  = (win_score == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      code_q <= '0;
      nof_q  <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      done_q <= done_d;
      row_q  <= row_d;
      code_q <= code_d;
      nof_q  <= nof_d;
    end
  end

  assign res_done    = done_q;
  assign res_row     = row_q;
  assign res_code    = code_q;
  assign res_nofocus = nof_q;

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_done |=> !res_done);

  // R6: results only move together with a done pulse
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !res_done |-> ($stable(res_row) && $stable(res_code) && $stable(res_nofocus)));

  // R4: reported code follows the reported row
  a_r4_code_map: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_done |-> (32'(res_code) == BASE_CODE + (32'(res_row) - 1) * CODE_STEP));

  // R5: an all-zero frame reports the first row
  a_r5_nofocus_row1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_nofocus |-> (res_row == IDX_W'(1)) && (res_code == CODE_W'(BASE_CODE)));

  // R7: once up, ready stays up
  a_r7_ready_stays: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |=> in_ready);
endmodule

// File: tb/sim_rng_focus_ranger.sv
`timescale 1ns/1ps
module sim_rng_focus_ranger;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sof, in_eor;
  logic [7:0] in_pix;
  logic       res_done, res_nofocus;
  logic [4:0] res_row;
  logic [7:0] res_code;

  always #2.5 clk = ~clk;

  rng_focus_ranger u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eor(in_eor), .in_pix(in_pix),
    .res_done(res_done), .res_row(res_row),
    .res_code(res_code), .res_nofocus(res_nofocus)
  );

  int n_chk = 0;
  int n_bad = 0;
  int prev_row = 0;
  bit finished = 1'b0;
  logic [7:0] img [18][16];

  typedef struct packed {
    logic [4:0] s1;
    logic [7:0] a1;
    logic [4:0] s2;
    logic [7:0] a2;
    logic [4:0] erow;
    logic       enof;
    logic       gap;
  } vec_t;

  // sharp row s1 with amplitude a1, second row s2 with a2 (0-based rows);
  // alternating 0/a rows score 28*a, flat rows score 0
  localparam vec_t VECS [8] = '{
    '{5'd0,  8'd200, 5'd5,  8'd50,  5'd1,  1'b0, 1'b0},
    '{5'd17, 8'd10,  5'd3,  8'd9,   5'd18, 1'b0, 1'b1},
    '{5'd9,  8'd80,  5'd10, 8'd79,  5'd10, 1'b0, 1'b0},
    '{5'd12, 8'd255, 5'd0,  8'd254, 5'd13, 1'b0, 1'b1},
    '{5'd7,  8'd60,  5'd4,  8'd60,  5'd5,  1'b0, 1'b0},
    '{5'd2,  8'd1,   5'd16, 8'd0,   5'd3,  1'b0, 1'b1},
    '{5'd5,  8'd0,   5'd6,  8'd0,   5'd1,  1'b1, 1'b0},
    '{5'd3,  8'd0,   5'd14, 8'd2,   5'd15, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic fill_flat(input int v);
    for (int r = 0; r < 18; r++)
      for (int c = 0; c < 16; c++) img[r][c] = 8'(v);
  endtask

  task automatic fill_pat(input int s1, input int a1, input int s2, input int a2);
    fill_flat(100);
    for (int c = 0; c < 16; c++) begin
      img[s2][c] = (c % 2 == 1) ? 8'(a2) : 8'd0;
      img[s1][c] = (c % 2 == 1) ? 8'(a1) : 8'd0;
    end
  endtask

  task automatic send_rows(input int nrows, input bit gap);
    int k;
    k = 0;
    for (int r = 0; r < nrows; r++) begin
      for (int c = 0; c < 16; c++) begin
        if (gap && (k % 5 == 4)) begin
          @(negedge clk);
          in_valid = 1'b0; in_pix = 8'hEE; in_sof = 1'b1; in_eor = 1'b1;  // R7 junk
        end
        @(negedge clk);
        if (r == 9 && c == 0) begin
          check("R6 no done mid-frame", int'(res_done), 0);
          check("R6 held row mid-frame", int'(res_row), prev_row);
        end
        in_valid = 1'b1;
        in_pix   = img[r][c];
        in_sof   = (r == 0 && c == 0);
        in_eor   = (c == 15);
        k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eor = 1'b0;
  endtask

  task automatic expect_result(input string tag, input int row, input int nof);
    check({tag, " done"}, int'(res_done), 1);
    check({tag, " row"},  int'(res_row), row);
    check({tag, " code R4"}, int'(res_code), row + 2);
    check({tag, " nofocus R5"}, int'(res_nofocus), nof);
    @(negedge clk);
    check("R6 done one cycle", int'(res_done), 0);
    check("R6 row held", int'(res_row), row);
    prev_row = row;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eor = 1'b0; in_pix = 8'd0;
    repeat (3) @(negedge clk);
    check("R8 reset done", int'(res_done), 0);
    check("R8 reset row", int'(res_row), 0);
    check("R8 reset code", int'(res_code), 0);
    check("R8 reset nofocus", int'(res_nofocus), 0);
    check("R8 reset ready", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 ready after reset", int'(in_ready), 1);

    // table walk: R3 winner/tie, R4 codes 3/20/12/15, R5 all-zero, R7 gaps
    for (int i = 0; i < 8; i++) begin
      fill_pat(int'(VECS[i].s1), int'(VECS[i].a1), int'(VECS[i].s2), int'(VECS[i].a2));
      send_rows(18, VECS[i].gap);
      expect_result($sformatf("R3 vec%0d", i), int'(VECS[i].erow), int'(VECS[i].enof));
    end

    // R1: a spike gives a negative term on each side; magnitudes give 400,
    // beating an alternating row of 28*14 = 392 (row 4 -> code 6)
    fill_flat(100);
    img[3][5] = 8'd200;
    for (int c = 0; c < 16; c++) img[8][c] = (c % 2 == 1) ? 8'd14 : 8'd0;
    send_rows(18, 1'b0);
    expect_result("R1 magnitude", 4, 0);

    // R2: row 5 with zero edge pixels scores 200 (terms only at cols 1, 14);
    // row 9 spike of 151 scores 204 -> row 10 wins, no cross-row terms
    fill_flat(100);
    img[5][0] = 8'd0; img[5][15] = 8'd0;
    img[9][7] = 8'd151;
    send_rows(18, 1'b1);
    expect_result("R2 window", 10, 0);

    // R9: abandoned partial frame with a sharp row, then a fresh frame
    fill_pat(2, 255, 3, 200);
    send_rows(5, 1'b0);
    check("R9 partial frame no done", int'(res_done), 0);
    check("R9 partial frame row held", int'(res_row), prev_row);
    fill_pat(11, 5, 0, 0);
    send_rows(18, 1'b0);
    expect_result("R9 restart", 12, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule